// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital controller wrapped around a 10-bit successive-approximation converter. Software sets an enable bit and a start bit, picks a conversion-clock source, a trigger mode, a channel and a result layout. The block then runs a conversion of fixed length. It presents a trial code to the external comparator and reads back the comparator decision. When it finishes, it raises a sticky completion flag and loads the result into a high byte and a low byte. The multiplexer, reference and comparator sit outside. The block only holds the channel code steady on `mux_sel` while a conversion runs.

Conversions are paced by a conversion-clock tick. The tick comes either from a power-of-two division of the system clock or from one of two external overflow pulses. Every conversion lasts 30 ticks: 2 sample ticks, 10 bit-trial ticks (MSB first) and 18 hold ticks.

The state machine has five states:
- `ST_IDLE`: no conversion.
- `ST_SAMPLE`: sampling.
- `ST_TRIAL`: bit trials.
- `ST_HOLD`: hold ticks.
- `ST_WAIT`: armed, waiting for a timer overflow.

Its transitions are:
- launch: `ST_IDLE` to `ST_SAMPLE` when enabled with the start bit set.
- sample-end: `ST_SAMPLE` to `ST_TRIAL` on the second tick.
- trials-end: `ST_TRIAL` to `ST_HOLD` on the tick that tests bit 0.
- finish: from `ST_HOLD` on the 30th tick. It goes to `ST_IDLE` in manual mode, back to `ST_SAMPLE` in free-run mode, or to `ST_WAIT` in timer mode.
- relaunch: `ST_WAIT` to `ST_SAMPLE` on a timer overflow, or at once if free-run is selected.
- disarm: `ST_WAIT` to `ST_IDLE` when the mode returns to manual.
- abort: any state to `ST_IDLE` when the enable bit is low.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With `cfg_clk_sel` = k for k in 0..5, the conversion clock ticks once every 2^k system clocks. In manual mode, `done_flag` reads 1 exactly 30·2^k + 1 rising edges after the edge that captures `start_wr`.
- R2: `cfg_clk_sel` = 6 takes one tick per `brg_ovf` pulse, and 7 takes one tick per `tmr_ovf` pulse. A conversion completes on the 30th pulse of the selected source and not before. Pulses on the other source have no effect.
- R3: A `start_wr` pulse sets `start_bit` on the next edge only while `cfg_en` is 1. With `cfg_en` at 0 the pulse is ignored and no conversion follows.
- R4: On completion, `done_flag` is set and the result bytes are loaded on the same edge. In manual mode (`cfg_trig` 0 or 3) `start_bit` clears on that edge. The result bytes change at no other time.
- R5: The result is a binary search driven by `cmp_hi`. `sar_code` shows the kept bits plus the bit under trial, MSB first. A trial bit is kept when `cmp_hi` is 1. `sar_code` is 0 while sampling.
- R6: `cfg_rjust` = 0 (left) puts result[9:2] in `res_hi` and result[1:0] in `res_lo[7:6]`, with the rest zero. `cfg_rjust` = 1 (right) puts result[9:8] in `res_hi[1:0]` and result[7:0] in `res_lo`.
- R7: In timer mode (`cfg_trig` = 1), the first conversion starts from `start_wr`. Each later one starts on the edge that captures a `tmr_ovf` pulse after the previous one has finished, and completes 30 ticks later. `start_bit` stays 1, and a pulse that arrives during a conversion is ignored. Returning to manual mode while waiting clears `start_bit`.
- R8: In free-run mode (`cfg_trig` = 2), each completion starts the next conversion on the same edge. Switching to manual mid-conversion lets that conversion finish, then clears `start_bit` and stops.
- R9: With `cfg_en` low, `start_bit` is 0 from the next edge. A conversion in progress is dropped, the result bytes keep their values and `done_flag` is not set.
- R10: Only a `done_clr` pulse clears `done_flag`. If completion and `done_clr` fall on the same edge, the flag stays set.
- R11: `irq` is 1 exactly while `done_flag` and `cfg_ie` are both 1.
- R12: `mux_sel` takes `cfg_chan` on the edge that starts a conversion and holds it until the next start.
- R13: After reset, `start_bit`, `done_flag`, `irq`, `res_hi`, `res_lo`, `mux_sel` and `sar_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Converter enable |
| cfg_clk_sel | input | 3 | Conversion-clock source: 0..5 divide by 2^k, 6 baud overflow, 7 timer-0 overflow |
| cfg_trig | input | 2 | Trigger mode: 0 manual, 1 timer overflow, 2 free-run, 3 manual |
| cfg_rjust | input | 1 | Result layout: 0 left, 1 right |
| cfg_chan | input | 4 | Channel select |
| cfg_ie | input | 1 | Interrupt enable |
| start_wr | input | 1 | One-cycle write of 1 to the start bit |
| done_clr | input | 1 | One-cycle clear of the completion flag |
| brg_ovf | input | 1 | Baud-rate generator overflow pulse |
| tmr_ovf | input | 1 | Timer-0 overflow pulse |
| cmp_hi | input | 1 | Comparator decision: input at or above trial level |
| start_bit | output | 1 | Start bit as read back |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |
| res_hi | output | 8 | High result byte |
| res_lo | output | 8 | Low result byte |
| mux_sel | output | 4 | Channel code held for the external multiplexer |
| sar_code | output | 10 | Trial code driven to the comparator DAC |

## Verification
A wrong tick count or a stuck state shows first as a completion latency that is off by whole conversion-clock periods. It can also show as a `done_flag` that never rises, which the latency checks catch within one conversion. A corrupted trial mask or kept-bit register cannot hide: the bench comparator answers from `sar_code`, so any error gives a wrong byte value at the very next completion. Repeat-mode mistakes, such as a lost arm, a spurious relaunch or a missed stop, show up within one conversion length as a `done_flag` that rises or stays low against the expected pattern, or as a wrong `start_bit`.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_TRIAL,
        ST_HOLD,
        ST_WAIT
    } conv_state_e;

    localparam logic [1:0] TRIG_MANUAL = 2'd0;
    localparam logic [1:0] TRIG_TIMER  = 2'd1;
    localparam logic [1:0] TRIG_FREE   = 2'd2;

    localparam logic [2:0] SRC_BRG = 3'd6;
    localparam logic [2:0] SRC_TMR = 3'd7;

    function automatic logic trig_is_manual(input logic [1:0] mode);
        return !(mode == TRIG_TIMER || mode == TRIG_FREE);
    endfunction

endpackage

// File: rtl/adc_clk_gen.sv
module adc_clk_gen
    import adc_seq_pkg::*;
#(
    parameter int DIV_CODES = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] sel,
    input  logic       brg_ovf,
    input  logic       tmr_ovf,
    output logic       tick
);

    localparam int CNT_W = (DIV_CODES > 1) ? DIV_CODES - 1 : 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_last;
    logic             internal_src;

    // Decode the division terminal count from the select code.
    always_comb begin
        cnt_last     = '0;
        internal_src = 1'b0;
        for (int k = 0; k < DIV_CODES; k++) begin
            if (sel == 3'(k)) begin
                cnt_last     = CNT_W'((1 << k) - 1);
                internal_src = 1'b1;
            end
        end
    end

    always_comb begin
        if (sel == SRC_BRG) begin
            tick = run & brg_ovf;
        end else if (sel == SRC_TMR) begin
            tick = run & tmr_ovf;
        end else begin
            tick = run & internal_src & (cnt == cnt_last);
        end
    end

    // Divider phase restarts with every conversion so latency is exact.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else if (internal_src) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/adc_sar_fsm.sv
module adc_sar_fsm
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int CONV_CLKS   = 30,
    parameter int SAMPLE_CLKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start_bit,
    input  logic [1:0]       trig,
    input  logic             tick,
    input  logic             tmr_ovf,
    input  logic             cmp_hi,
    output conv_state_e      state,
    output logic             active,
    output logic             launch,
    output logic             finish,
    output logic             clr_start,
    output logic [RES_W-1:0] sar_code,
    output logic [RES_W-1:0] result
);

    localparam int STEP_W = $clog2(CONV_CLKS + 1);
    localparam logic [STEP_W-1:0] SAMPLE_LAST = STEP_W'(SAMPLE_CLKS - 1);
    localparam logic [STEP_W-1:0] CONV_LAST   = STEP_W'(CONV_CLKS - 1);
    localparam logic [RES_W-1:0]  TRIAL_MSB   = RES_W'(1) << (RES_W - 1);

    conv_state_e      st;
    conv_state_e      st_nxt;
    logic [STEP_W-1:0] step;
    logic [RES_W-1:0]  sar;
    logic [RES_W-1:0]  mask;
    logic              manual;
    logic              last_tick;

    assign manual    = trig_is_manual(trig);
    assign last_tick = tick && (step == CONV_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        st_nxt = st;
        if (!en) begin
            st_nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start_bit) st_nxt = ST_SAMPLE;
                end
                ST_SAMPLE: begin
                    if (tick && step == SAMPLE_LAST) st_nxt = ST_TRIAL;
                end
                ST_TRIAL: begin
                    if (tick && mask[0]) st_nxt = ST_HOLD;
                end
                ST_HOLD: begin
                    if (last_tick) begin
                        if (manual)                 st_nxt = ST_IDLE;
                        else if (trig == TRIG_FREE) st_nxt = ST_SAMPLE;
                        else                        st_nxt = ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (manual) st_nxt = ST_IDLE;
                    else if (trig == TRIG_FREE || tmr_ovf) st_nxt = ST_SAMPLE;
                end
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    // Output logic
    always_comb begin
        active    = (st == ST_SAMPLE) || (st == ST_TRIAL) || (st == ST_HOLD);
        finish    = en && (st == ST_HOLD) && last_tick;
        launch    = en && (((st == ST_IDLE) && start_bit) ||
                           ((st == ST_WAIT) && !manual &&
                            (trig == TRIG_FREE || tmr_ovf)) ||
                           (finish && trig == TRIG_FREE));
        clr_start = manual && (finish || (st == ST_WAIT));
        sar_code  = sar | mask;
        result    = sar;
        state     = st;
    end

    // Step counter, kept bits and one-hot trial mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step <= '0;
            sar  <= '0;
            mask <= '0;
        end else if (launch) begin
            step <= '0;
            sar  <= '0;
            mask <= '0;
        end else if (!en) begin
            mask <= '0;
        end else if (active && tick) begin
            step <= step + 1'b1;
            if (st == ST_SAMPLE && step == SAMPLE_LAST) begin
                mask <= TRIAL_MSB;
            end
            if (st == ST_TRIAL) begin
                if (cmp_hi) sar <= sar | mask;
                mask <= mask >> 1;
            end
        end
    end

endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs #(
    parameter int RES_W  = 10,
    parameter int CHAN_W = 4,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start_wr,
    input  logic              done_clr,
    input  logic              rjust,
    input  logic [CHAN_W-1:0] chan,
    input  logic              launch,
    input  logic              finish,
    input  logic              clr_start,
    input  logic [RES_W-1:0]  result,
    output logic              start_bit,
    output logic              done_flag,
    output logic [BYTE_W-1:0] res_hi,
    output logic [BYTE_W-1:0] res_lo,
    output logic [CHAN_W-1:0] mux_sel
);

    localparam int PACK_W = 2 * BYTE_W;

    logic [PACK_W-1:0] pk_left;
    logic [PACK_W-1:0] pk_right;
    logic [PACK_W-1:0] pk_sel;

    assign pk_left  = PACK_W'(result) << (PACK_W - RES_W);
    assign pk_right = PACK_W'(result);
    assign pk_sel   = rjust ? pk_right : pk_left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_bit <= 1'b0;
        end else if (!en || clr_start) begin
            start_bit <= 1'b0;
        end else if (start_wr) begin
            start_bit <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
        end else if (finish) begin
            done_flag <= 1'b1;
        end else if (done_clr) begin
            done_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_hi <= '0;
            res_lo <= '0;
        end else if (finish) begin
            res_hi <= pk_sel[PACK_W-1:BYTE_W];
            res_lo <= pk_sel[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mux_sel <= '0;
        end else if (launch) begin
            mux_sel <= chan;
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int CONV_CLKS   = 30,
    parameter int SAMPLE_CLKS = 2,
    parameter int CHAN_W      = 4,
    parameter int BYTE_W      = 8,
    parameter int DIV_CODES   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [2:0]        cfg_clk_sel,
    input  logic [1:0]        cfg_trig,
    input  logic              cfg_rjust,
    input  logic [CHAN_W-1:0] cfg_chan,
    input  logic              cfg_ie,
    input  logic              start_wr,
    input  logic              done_clr,
    input  logic              brg_ovf,
    input  logic              tmr_ovf,
    input  logic              cmp_hi,
    output logic              start_bit,
    output logic              done_flag,
    output logic              irq,
    output logic [BYTE_W-1:0] res_hi,
    output logic [BYTE_W-1:0] res_lo,
    output logic [CHAN_W-1:0] mux_sel,
    output logic [RES_W-1:0]  sar_code
);

    conv_state_e      st;
    logic             tick;
    logic             active;
    logic             launch;
    logic             finish;
    logic             clr_start;
    logic [RES_W-1:0] result;

    adc_clk_gen #(
        .DIV_CODES (DIV_CODES)
    ) u_clk_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (active),
        .sel     (cfg_clk_sel),
        .brg_ovf (brg_ovf),
        .tmr_ovf (tmr_ovf),
        .tick    (tick)
    );

    adc_sar_fsm #(
        .RES_W       (RES_W),
        .CONV_CLKS   (CONV_CLKS),
        .SAMPLE_CLKS (SAMPLE_CLKS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_en),
        .start_bit (start_bit),
        .trig      (cfg_trig),
        .tick      (tick),
        .tmr_ovf   (tmr_ovf),
        .cmp_hi    (cmp_hi),
        .state     (st),
        .active    (active),
        .launch    (launch),
        .finish    (finish),
        .clr_start (clr_start),
        .sar_code  (sar_code),
        .result    (result)
    );

    adc_ctrl_regs #(
        .RES_W  (RES_W),
        .CHAN_W (CHAN_W),
        .BYTE_W (BYTE_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_en),
        .start_wr  (start_wr),
        .done_clr  (done_clr),
        .rjust     (cfg_rjust),
        .chan      (cfg_chan),
        .launch    (launch),
        .finish    (finish),
        .clr_start (clr_start),
        .result    (result),
        .start_bit (start_bit),
        .done_flag (done_flag),
        .res_hi    (res_hi),
        .res_lo    (res_lo),
        .mux_sel   (mux_sel)
    );

    assign irq = done_flag & cfg_ie;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
    import adc_seq_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int CHAN_W = 4,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_en,
    input logic              done_clr,
    input logic              start_bit,
    input logic              done_flag,
    input logic [BYTE_W-1:0] res_hi,
    input logic [BYTE_W-1:0] res_lo,
    input logic [CHAN_W-1:0] mux_sel,
    input logic [RES_W-1:0]  sar_code,
    input conv_state_e       st
);

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_bit) |-> $past(cfg_en));  // R3

    AST_DONE_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> ($past(st) == ST_HOLD));  // R4

    AST_RESULT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({res_hi, res_lo}) |-> done_flag);  // R4

    AST_SAMPLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SAMPLE) |-> (sar_code == '0));  // R5

    AST_WAIT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> start_bit);  // R7

    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!start_bit && st == ST_IDLE));  // R9

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !done_clr) |=> done_flag);  // R10

    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TRIAL || st == ST_HOLD) |-> $stable(mux_sel));  // R12

endmodule

bind adc_seq_ctrl adc_seq_chk #(
    .RES_W  (RES_W),
    .CHAN_W (CHAN_W),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .done_clr  (done_clr),
    .start_bit (start_bit),
    .done_flag (done_flag),
    .res_hi    (res_hi),
    .res_lo    (res_lo),
    .mux_sel   (mux_sel),
    .sar_code  (sar_code),
    .st        (st)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {clk_sel, rjust, input level, expected high byte, expected low byte}
    localparam logic [29:0] VEC [0:NVEC-1] = '{
        {3'd0, 1'b0, 10'h3FF, 8'hFF, 8'hC0},
        {3'd0, 1'b1, 10'h3FF, 8'h03, 8'hFF},
        {3'd1, 1'b0, 10'h000, 8'h00, 8'h00},
        {3'd2, 1'b1, 10'h2A5, 8'h02, 8'hA5},
        {3'd0, 1'b0, 10'h2A5, 8'hA9, 8'h40},
        {3'd3, 1'b0, 10'h155, 8'h55, 8'h40},
        {3'd1, 1'b1, 10'h200, 8'h02, 8'h00},
        {3'd5, 1'b1, 10'h001, 8'h00, 8'h01}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic [2:0] cfg_clk_sel = 3'd0;
    logic [1:0] cfg_trig = 2'd0;
    logic       cfg_rjust = 1'b0;
    logic [3:0] cfg_chan = 4'd0;
    logic       cfg_ie = 1'b0;
    logic       start_wr = 1'b0;
    logic       done_clr = 1'b0;
    logic       brg_ovf = 1'b0;
    logic       tmr_ovf = 1'b0;
    logic       cmp_hi;
    logic       start_bit;
    logic       done_flag;
    logic       irq;
    logic [7:0] res_hi;
    logic [7:0] res_lo;
    logic [3:0] mux_sel;
    logic [9:0] sar_code;

    logic [9:0]  vin = 10'd0;
    logic [2:0]  v_sel;
    logic        v_rj;
    logic [9:0]  v_in;
    logic [7:0]  v_hi;
    logic [7:0]  v_lo;
    logic [15:0] saved;
    int          cyc;
    int          checks = 0;
    int          errors = 0;

    // Comparator model: input at or above the trial level
    assign cmp_hi = (vin >= sar_code);

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_seq_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_en      (cfg_en),
        .cfg_clk_sel (cfg_clk_sel),
        .cfg_trig    (cfg_trig),
        .cfg_rjust   (cfg_rjust),
        .cfg_chan    (cfg_chan),
        .cfg_ie      (cfg_ie),
        .start_wr    (start_wr),
        .done_clr    (done_clr),
        .brg_ovf     (brg_ovf),
        .tmr_ovf     (tmr_ovf),
        .cmp_hi      (cmp_hi),
        .start_bit   (start_bit),
        .done_flag   (done_flag),
        .irq         (irq),
        .res_hi      (res_hi),
        .res_lo      (res_lo),
        .mux_sel     (mux_sel),
        .sar_code    (sar_code)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_wr = 1'b1;
        @(negedge clk) start_wr = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk) done_clr = 1'b1;
        @(negedge clk) done_clr = 1'b0;
    endtask

    task automatic pulse_brg();
        @(negedge clk) brg_ovf = 1'b1;
        @(negedge clk) brg_ovf = 1'b0;
    endtask

    task automatic pulse_tmr();
        @(negedge clk) tmr_ovf = 1'b1;
        @(negedge clk) tmr_ovf = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done_flag) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check("R13 start_bit", start_bit, 0);
        check("R13 done_flag", done_flag, 0);
        check("R13 irq", irq, 0);
        check("R13 result", {res_hi, res_lo}, 0);
        check("R13 mux_sel", mux_sel, 0);
        check("R13 sar_code", sar_code, 0);

        cfg_en = 1'b1;
        cfg_trig = 2'd0;

        // Vector table: divider latency, SAR search, layout
        for (int i = 0; i < NVEC; i++) begin
            {v_sel, v_rj, v_in, v_hi, v_lo} = VEC[i];
            @(negedge clk);
            cfg_clk_sel = v_sel;
            cfg_rjust = v_rj;
            vin = v_in;
            pulse_clr();
            pulse_start();
            wait_done(cyc);
            check("R1 latency", cyc, 30 * (1 << v_sel) + 1);
            check("R5 R6 res_hi", res_hi, v_hi);
            check("R5 R6 res_lo", res_lo, v_lo);
            check("R4 start self-clear", start_bit, 0);
        end

        // R2: external tick source, other pulse ignored
        cfg_clk_sel = 3'd6;
        cfg_rjust = 1'b1;
        vin = 10'h155;
        pulse_clr();
        pulse_start();
        pulse_tmr();
        repeat (29) pulse_brg();
        check("R2 not done after 29 pulses", done_flag, 0);
        pulse_brg();
        check("R2 done on 30th pulse", done_flag, 1);
        check("R2 result", {res_hi, res_lo}, 16'h0155);

        // R3: start ignored while disabled
        cfg_clk_sel = 3'd0;
        cfg_en = 1'b0;
        pulse_clr();
        pulse_start();
        check("R3 start ignored", start_bit, 0);
        repeat (40) @(negedge clk);
        check("R3 no conversion", done_flag, 0);
        cfg_en = 1'b1;

        // R9: abort
        cfg_rjust = 1'b0;
        vin = 10'h3FF;
        saved = {res_hi, res_lo};
        pulse_start();
        repeat (10) @(negedge clk);
        cfg_en = 1'b0;
        @(negedge clk);
        check("R9 start cleared", start_bit, 0);
        repeat (50) @(negedge clk);
        check("R9 no done", done_flag, 0);
        check("R9 result kept", {res_hi, res_lo}, saved);
        cfg_en = 1'b1;
        repeat (40) @(negedge clk);
        check("R9 no restart", start_bit, 0);
        check("R9 still no done", done_flag, 0);

        // R10 / R11: sticky flag and interrupt
        cfg_ie = 1'b0;
        pulse_start();
        wait_done(cyc);
        check("R11 irq masked", irq, 0);
        @(negedge clk) cfg_ie = 1'b1;
        @(negedge clk);
        check("R11 irq asserted", irq, 1);
        repeat (60) @(negedge clk);
        check("R10 flag sticky", done_flag, 1);
        pulse_clr();
        check("R10 flag cleared", done_flag, 0);
        check("R11 irq dropped", irq, 0);

        // R12: channel latched at start
        cfg_chan = 4'd5;
        pulse_start();
        repeat (6) @(negedge clk);
        check("R12 mux latched", mux_sel, 5);
        cfg_chan = 4'd9;
        repeat (5) @(negedge clk);
        check("R12 mux held", mux_sel, 5);
        wait_done(cyc);
        check("R12 mux held at end", mux_sel, 5);
        pulse_clr();
        pulse_start();
        repeat (3) @(negedge clk);
        check("R12 new channel", mux_sel, 9);
        wait_done(cyc);
        pulse_clr();

        // R7: timer-overflow mode
        cfg_trig = 2'd1;
        cfg_rjust = 1'b1;
        vin = 10'h0AA;
        pulse_start();
        wait_done(cyc);
        check("R7 first latency", cyc, 31);
        check("R7 start stays set", start_bit, 1);
        pulse_clr();
        repeat (40) @(negedge clk);
        check("R7 waits for overflow", done_flag, 0);
        vin = 10'h123;
        pulse_tmr();
        repeat (8) @(negedge clk);
        pulse_tmr();
        wait_done(cyc);
        check("R7 overflow latency", cyc, 20);
        check("R7 result", {res_hi, res_lo}, 16'h0123);
        pulse_clr();
        repeat (60) @(negedge clk);
        check("R7 busy overflow ignored", done_flag, 0);
        cfg_trig = 2'd0;
        repeat (2) @(negedge clk);
        check("R7 manual disarms", start_bit, 0);

        // R8: free-running mode
        cfg_trig = 2'd2;
        vin = 10'h100;
        pulse_start();
        wait_done(cyc);
        check("R8 first latency", cyc, 31);
        check("R8 first result", {res_hi, res_lo}, 16'h0100);
        vin = 10'h0F0;
        pulse_clr();
        wait_done(cyc);
        check("R8 back-to-back", cyc, 28);
        check("R8 second result", {res_hi, res_lo}, 16'h00F0);
        cfg_trig = 2'd0;
        pulse_clr();
        wait_done(cyc);
        check("R8 stop after current", start_bit, 0);
        pulse_clr();
        repeat (80) @(negedge clk);
        check("R8 no further conversion", done_flag, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule